// File: doc/BRIEF.md
# Registered Bidirectional Bus Transceiver

The block links two 8-bit bidirectional buses, called A and B. Each bus pad is modelled by three signals: an input vector, an output vector and a single output-enable bit. An active-low output enable and a direction input pick which side, if any, drives. When the output enable is high, neither side drives.

Two independent edge-triggered registers hold one word for each direction. One captures the A bus on its own clock and feeds B. The other captures the B bus on a second clock and feeds A. A per-direction source select lets each driven side carry either the live word from the opposite bus or the stored word. Capture never depends on the enable or the direction, so words can still be stored while both sides are isolated. An asynchronous active-low reset clears both registers and leaves the enable logic untouched.

Top module: `bus_xcvr_reg`

## Requirements
- R1: On every rising edge of `cap_ab_clk`, the value on `a_in` is stored in the A-to-B register, whatever the values of `oe_n` and `dir`.
- R2: On every rising edge of `cap_ba_clk`, the value on `b_in` is stored in the B-to-A register, whatever the values of `oe_n` and `dir`.
- R3: While `oe_n` is 1 (isolation), `a_oe` and `b_oe` are both 0, and R1 and R2 still capture.
- R4: While `oe_n` is 0 and `dir` is 1, `b_oe` is 1 and `a_oe` is 0.
- R5: While `oe_n` is 0 and `dir` is 0, `a_oe` is 1 and `b_oe` is 0. `a_oe` and `b_oe` are never both 1, and both follow `oe_n` and `dir` combinationally, with no clock.
- R6: `b_out` equals `a_in` combinationally when `sel_ab` is 0, and equals the A-to-B register when `sel_ab` is 1. This holds whatever the value of `b_oe`.
- R7: `a_out` equals `b_in` combinationally when `sel_ba` is 0, and equals the B-to-A register when `sel_ba` is 1. This holds whatever the value of `a_oe`.
- R8: In stored mode, a capture edge makes the newly stored word appear on the corresponding output right after that edge.
- R9: While `rst_n` is 0, both registers are cleared to 0 without any clock. During reset, `a_oe` and `b_oe` still follow R3 to R5.
- R10: A register keeps its value between capture edges, whatever happens on the bus inputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rst_n | input | 1 | Asynchronous active-low clear of both registers |
| cap_ab_clk | input | 1 | Rising-edge capture of the A bus |
| cap_ba_clk | input | 1 | Rising-edge capture of the B bus |
| sel_ab | input | 1 | B-side source: 0 live A, 1 stored |
| sel_ba | input | 1 | A-side source: 0 live B, 1 stored |
| oe_n | input | 1 | Active-low output enable |
| dir | input | 1 | 1: B drives, 0: A drives |
| a_in | input | 8 | A pad input |
| a_out | output | 8 | A pad output value |
| a_oe | output | 1 | A pad driver enable |
| b_in | input | 8 | B pad input |
| b_out | output | 8 | B pad output value |
| b_oe | output | 1 | B pad driver enable |

## Verification
At each capture edge, the assertions check four things: the two pad enables are never both high, isolation forces both enables low, a transparent output matches the opposite live bus, and the register holds the word sampled at the previous edge of its own clock. Some behaviour can only be shown by the bench's scenarios. This covers enables that switch at once with no edge and a reset that clears the registers with no clock. It also covers stored words that survive bus activity between edges, and a stored-mode output that changes right after its edge.

// File: rtl/bus_xcvr_reg.sv
module bus_xcvr_reg #(
  parameter int W = 8
) (
  input  logic         rst_n,
  input  logic         cap_ab_clk,
  input  logic         cap_ba_clk,
  input  logic         sel_ab,
  input  logic         sel_ba,
  input  logic         oe_n,
  input  logic         dir,
  input  logic [W-1:0] a_in,
  output logic [W-1:0] a_out,
  output logic         a_oe,
  input  logic [W-1:0] b_in,
  output logic [W-1:0] b_out,
  output logic         b_oe
);

  logic [W-1:0] ab_q, ba_q;

  always_ff @(posedge cap_ab_clk or negedge rst_n)
    if (!rst_n) ab_q <= '0;
    else        ab_q <= a_in;

  always_ff @(posedge cap_ba_clk or negedge rst_n)
    if (!rst_n) ba_q <= '0;
    else        ba_q <= b_in;

  assign b_out = sel_ab ? ab_q : a_in;
  assign a_out = sel_ba ? ba_q : b_in;
  assign b_oe  = ~oe_n &  dir;
  assign a_oe  = ~oe_n & ~dir;

  a_r5_enables_exclusive_ab: assert property (@(posedge cap_ab_clk) disable iff (!rst_n)
    !(a_oe && b_oe));
  a_r5_enables_exclusive_ba: assert property (@(posedge cap_ba_clk) disable iff (!rst_n)
    !(a_oe && b_oe));
  a_r3_isolation_quiet: assert property (@(posedge cap_ab_clk) disable iff (!rst_n)
    oe_n |-> (!a_oe && !b_oe));
  a_r6_transparent_b: assert property (@(posedge cap_ab_clk) disable iff (!rst_n)
    !sel_ab |-> (b_out == a_in));
  a_r7_transparent_a: assert property (@(posedge cap_ba_clk) disable iff (!rst_n)
    !sel_ba |-> (a_out == b_in));
  a_r1_capture_ab: assert property (@(posedge cap_ab_clk) disable iff (!rst_n)
    1'b1 |=> (ab_q == $past(a_in)));
  a_r2_capture_ba: assert property (@(posedge cap_ba_clk) disable iff (!rst_n)
    1'b1 |=> (ba_q == $past(b_in)));

endmodule

// File: tb/tb_bus_xcvr_reg.sv
`timescale 1ns/1ps
module tb_bus_xcvr_reg;
  logic clk = 0;
  always #10 clk = ~clk;

  logic rst_n, cap_ab_clk, cap_ba_clk, sel_ab, sel_ba, oe_n, dir;
  logic [7:0] a_in, b_in, a_out, b_out;
  logic a_oe, b_oe;

  bus_xcvr_reg #(.W(8)) dut (
    .rst_n(rst_n), .cap_ab_clk(cap_ab_clk), .cap_ba_clk(cap_ba_clk),
    .sel_ab(sel_ab), .sel_ba(sel_ba), .oe_n(oe_n), .dir(dir),
    .a_in(a_in), .a_out(a_out), .a_oe(a_oe),
    .b_in(b_in), .b_out(b_out), .b_oe(b_oe));

  int checks = 0, fails = 0;
  logic [7:0] mab, mba;
  bit done = 0;

  task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic verify(string dtag);
    string etag;
    #1;
    etag = oe_n ? "R3" : (dir ? "R4" : "R5");
    chk({etag, " a_oe"}, {7'd0, a_oe}, {7'd0, ~oe_n & ~dir});
    chk({etag, " b_oe"}, {7'd0, b_oe}, {7'd0, ~oe_n & dir});
    chk({dtag, " b_out"}, b_out, sel_ab ? mab : a_in);
    chk({dtag, " a_out"}, a_out, sel_ba ? mba : b_in);
  endtask

  task automatic pulse_ab();
    cap_ab_clk = 1; mab = a_in; #5 cap_ab_clk = 0; #2;
  endtask
  task automatic pulse_ba();
    cap_ba_clk = 1; mba = b_in; #5 cap_ba_clk = 0; #2;
  endtask

  initial begin
    int cyc = 0;
    while (!done) begin
      @(posedge clk);
      cyc++;
      if (cyc > 100000) begin
        fails++; checks++;
        $display("FAIL watchdog expired");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
      end
    end
  end

  initial begin
    rst_n = 0; cap_ab_clk = 0; cap_ba_clk = 0;
    sel_ab = 1; sel_ba = 1; oe_n = 0; dir = 1;
    a_in = 8'h5A; b_in = 8'hA5; mab = 0; mba = 0;
    #20 verify("R9");
    dir = 0; verify("R9");
    rst_n = 1; #5;

    for (int c = 0; c < 16; c++) begin
      for (int k = 0; k < 4; k++) begin
        {oe_n, dir, sel_ab, sel_ba} = c[3:0];
        a_in = 8'(c * 16 + k * 5 + 3);
        b_in = ~a_in ^ 8'(k);
        verify("R6");
        if (k[0]) pulse_ab();
        if (k[1]) pulse_ba();
        verify(k[0] ? "R1" : "R7");
        verify(oe_n ? "R3" : "R8");
        a_in = a_in ^ 8'hFF;
        b_in = b_in + 8'd77;
        verify("R10");
        dir = ~dir;
        verify("R5");
        oe_n = ~oe_n;
        verify("R3");
      end
    end

    sel_ab = 1; sel_ba = 1; oe_n = 1;
    a_in = 8'hC3; pulse_ab();
    b_in = 8'h3C; pulse_ba();
    verify("R2");
    rst_n = 0; mab = 0; mba = 0;
    verify("R9");
    #5 rst_n = 1;
    verify("R9");

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule